// File: doc/BRIEF.md
# Parallel NOR Flash Command Engine

This block is the command front end of a byte-wide parallel NOR flash. A host drives chip-select, write-strobe and read-strobe lines that are sampled on the core clock. Write strobes are decoded as multi-write unlock sequences that start byte programs, sector or whole-array erases, a shortened program mode, and erase suspend and resume. The engine runs each embedded operation against the cell array through a request/acknowledge port. It holds a ready/busy line low while an operation runs.

While an operation is busy, a host read returns a status byte instead of array data. Erases skip write-protected sectors. Before erasing, the engine first drives every non-zero byte of a targeted sector to zero. An erase can be paused so the host can read or program other sectors, then resumed. A low-supply input blocks every write. The asynchronous reset aborts whatever is running and returns the engine to plain array reads.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset, `ry_by_n` is 1, `arr_req` is 0 and `rdata` is 0x00. A read strobe (falling `oe_n` with `ce_n` low) returns the array byte at `addr` within four clocks.
- R2: The write sequence 0xAA at offset 0x555, 0x55 at offset 0x2AA, 0xA0 at 0x555, then data at a target address stores that byte in the array. Unlock offsets compare the low 11 address bits.
- R3: `ry_by_n` is 0 from the clock after the final write of a program or erase command until the operation ends. For a program this lasts at least `PROG_CYC` clocks. When `ry_by_n` rises, no array request is outstanding.
- R4: A read while busy returns a status byte. Bit 7 is the inverse of bit 7 of the byte being programmed, or 0 during an erase. Bit 6 inverts on each successive status read.
- R5: The six-write sequence ending in 0x30 erases the sector named by the top `SEC_W` address bits to 0xFF. Further 0x30 writes, each within `WIN_CYC` clocks of the previous one, add their sectors. Other sectors are unchanged.
- R6: The six-write sequence ending in 0x10 at 0x555 erases every unprotected sector to 0xFF.
- R7: During an erase, no 0xFF is written to a location that is not already 0x00. Non-zero locations are first written to 0x00.
- R8: After unlock plus 0x20, a program takes two writes (0xA0, then address/data). 0x90 followed by 0x00 leaves this mode, after which the two-write form is ignored.
- R9: A write that does not match the next expected step discards the partial sequence.
- R10: 0xB0 during an erase raises `ry_by_n` within a few clocks. While suspended, other sectors can be read and programmed, programs aimed at erasing sectors are ignored, and 0x30 resumes the erase to completion.
- R11: A program aimed at a sector whose `prot_mask` bit is 1 is ignored, and erases leave such sectors untouched. The array port never writes a protected sector.
- R12: While `lv_det` is 1, bus writes have no effect, and `ry_by_n` cannot fall.
- R13: Asserting `rst_n` aborts a running erase or a partial sequence. Afterwards reads return array data and `ry_by_n` is 1.
- R14: Once raised, `arr_req`, `arr_we`, `arr_addr` and `arr_wdata` hold until the clock that sees `arr_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status byte |
| ry_by_n | output | 1 | High when ready, low while busy |
| lv_det | input | 1 | Low-supply detect, blocks writes |
| prot_mask | input | 2**SEC_W | Per-sector write protect |
| arr_req | output | 1 | Array access request |
| arr_we | output | 1 | Array access is a write |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data, valid with ack |
| arr_ack | input | 1 | Array access done |

## Verification
The bench builds the engine with `ADDR_W=12`, so each of the 32 sectors holds 128 bytes. This lets a full chip erase, including its pre-program pass, finish within a short run, and lets a behavioural array record every 0xFF write that lands on a non-zero cell. `PROG_CYC=40` keeps a program busy long enough for two successive status reads, so the toggle bit can be seen. `WIN_CYC=20` allows three sector-select writes to chain inside one erase window, while a 30-clock wait still reaches the erase phase, where suspend and reset are applied.

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
  parameter int ADDR_W    = 21,
  parameter int SEC_W     = 5,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64,
  parameter int WIN_CYC   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    ry_by_n,
  input  logic                    lv_det,
  input  logic [(1<<SEC_W)-1:0]   prot_mask,
  output logic                    arr_req,
  output logic                    arr_we,
  output logic [ADDR_W-1:0]       arr_addr,
  output logic [7:0]              arr_wdata,
  input  logic [7:0]              arr_rdata,
  input  logic                    arr_ack
);
  localparam int SN    = 1 << SEC_W;
  localparam int OFF_W = ADDR_W - SEC_W;
  localparam int TMAX  = (PROG_CYC > ERASE_CYC) ? ((PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC)
                                                : ((ERASE_CYC > WIN_CYC) ? ERASE_CYC : WIN_CYC);
  localparam int TW    = $clog2(TMAX + 1) + 1;

  typedef enum logic [2:0] {OP_READ, OP_PROG, OP_EWIN, OP_ERASE, OP_SUSP} op_t;
  typedef enum logic [2:0] {Q0, Q1, Q2, Q3, Q4, Q5, QP, QX} seq_t;

  op_t               op;
  seq_t              seq;
  logic              byp, psus, susp_req, pw_done;
  logic [SN-1:0]     eset;
  logic [7:0]        pdata, rdata_q, a_wd;
  logic [ADDR_W-1:0] paddr, e_ptr, a_addr;
  logic [TW-1:0]     tmr;
  logic              e_ph, e_tmr, e_nz;
  logic [1:0]        e_st;
  logic              we_q, oe_q, rd_pend, tog, a_req, a_we;

  wire wr_stb = !ce_n && !we_n && we_q && !lv_det;
  wire rd_stb = !ce_n && !oe_n && oe_q;
  wire is555  = addr[10:0] == 11'h555;
  wire is2aa  = addr[10:0] == 11'h2AA;
  wire [SEC_W-1:0] asec  = addr[ADDR_W-1 -: SEC_W];
  wire [SEC_W-1:0] esec  = e_ptr[ADDR_W-1 -: SEC_W];
  wire susp   = op == OP_SUSP;
  wire busy   = op == OP_PROG || op == OP_EWIN || op == OP_ERASE;
  wire [7:0] status = {(op == OP_PROG) ? ~pdata[7] : 1'b0, tog, 6'b0};
  wire [SN-1:0] eset_ok = eset & ~prot_mask;

  assign ry_by_n   = !busy;
  assign rdata     = rdata_q;
  assign arr_req   = a_req;
  assign arr_we    = a_we;
  assign arr_addr  = a_addr;
  assign arr_wdata = a_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= OP_READ; seq <= Q0; byp <= 1'b0; psus <= 1'b0; susp_req <= 1'b0;
      pw_done <= 1'b0; eset <= '0; pdata <= '0; paddr <= '0; rdata_q <= '0;
      tmr <= '0; e_ptr <= '0; e_ph <= 1'b0; e_tmr <= 1'b0; e_nz <= 1'b0; e_st <= '0;
      we_q <= 1'b1; oe_q <= 1'b1; rd_pend <= 1'b0; tog <= 1'b0;
      a_req <= 1'b0; a_we <= 1'b0; a_addr <= '0; a_wd <= '0;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
      if (a_req && arr_ack) a_req <= 1'b0;

      if (rd_stb) begin
        if (busy) begin
          rdata_q <= status;
          tog     <= ~tog;
        end else begin
          rd_pend <= 1'b1;
          a_req   <= 1'b1;
          a_we    <= 1'b0;
          a_addr  <= addr;
        end
      end
      if (rd_pend && arr_ack) begin
        rdata_q <= arr_rdata;
        rd_pend <= 1'b0;
      end

      if (wr_stb) begin
        case (op)
          OP_READ, OP_SUSP: begin
            seq <= Q0;
            case (seq)
              Q0: begin
                if (byp && !susp) begin
                  if (wdata == 8'hA0) seq <= QP;
                  else if (wdata == 8'h90) seq <= QX;
                end else if (is555 && wdata == 8'hAA) seq <= Q1;
                else if (susp && wdata == 8'h30) op <= OP_ERASE;
              end
              Q1: if (is2aa && wdata == 8'h55) seq <= Q2;
              Q2: if (is555) begin
                if (wdata == 8'hA0) seq <= QP;
                else if (!susp && wdata == 8'h80) seq <= Q3;
                else if (!susp && wdata == 8'h20) byp <= 1'b1;
              end
              Q3: if (is555 && wdata == 8'hAA) seq <= Q4;
              Q4: if (is2aa && wdata == 8'h55) seq <= Q5;
              Q5: begin
                if (is555 && wdata == 8'h10) begin
                  eset <= ~prot_mask;
                  op   <= (&prot_mask) ? OP_READ : OP_ERASE;
                end else if (wdata == 8'h30) begin
                  eset <= SN'(1) << asec;
                  tmr  <= TW'(WIN_CYC);
                  op   <= OP_EWIN;
                end
              end
              QP: if (!prot_mask[asec] && !(susp && eset[asec])) begin
                op      <= OP_PROG;
                psus    <= susp;
                pdata   <= wdata;
                paddr   <= addr;
                pw_done <= 1'b0;
              end
              QX: if (wdata == 8'h00) byp <= 1'b0;
              default: ;
            endcase
          end
          OP_EWIN: begin
            if (wdata == 8'h30) begin
              eset[asec] <= 1'b1;
              tmr        <= TW'(WIN_CYC);
            end else begin
              op   <= OP_READ;
              eset <= '0;
            end
          end
          OP_ERASE: if (wdata == 8'hB0) susp_req <= 1'b1;
          default: ;
        endcase
      end

      if (op == OP_PROG) begin
        if (!pw_done) begin
          if (!a_req && !rd_pend) begin
            a_req   <= 1'b1;
            a_we    <= 1'b1;
            a_addr  <= paddr;
            a_wd    <= pdata;
            pw_done <= 1'b1;
            tmr     <= TW'(PROG_CYC);
          end
        end else if (!a_req) begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else op <= psus ? OP_SUSP : OP_READ;
        end
      end

      if (op == OP_EWIN && !wr_stb) begin
        if (tmr != '0) tmr <= tmr - 1'b1;
        else begin
          eset <= eset_ok;
          op   <= (eset_ok == '0) ? OP_READ : OP_ERASE;
        end
      end

      if (op == OP_READ || op == OP_EWIN) begin
        e_ptr <= '0; e_ph <= 1'b0; e_st <= '0; e_tmr <= 1'b0; susp_req <= 1'b0;
      end

      if (op == OP_ERASE && a_req && arr_ack && e_st == 2'd1) e_nz <= |arr_rdata;

      if (op == OP_ERASE) begin
        if (e_tmr) begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            op   <= OP_READ;
            eset <= '0;
          end
        end else if (!a_req) begin
          case (e_st)
            2'd0: begin
              if (susp_req) begin
                op       <= OP_SUSP;
                susp_req <= 1'b0;
              end else if (!eset[esec]) begin
                if (&esec) begin
                  if (!e_ph) begin e_ph <= 1'b1; e_ptr <= '0; end
                  else begin e_tmr <= 1'b1; tmr <= TW'(ERASE_CYC); end
                end else e_ptr <= {SEC_W'(esec + 1'b1), {OFF_W{1'b0}}};
              end else begin
                a_req  <= 1'b1;
                a_addr <= e_ptr;
                a_we   <= e_ph;
                a_wd   <= 8'hFF;
                e_st   <= e_ph ? 2'd2 : 2'd1;
              end
            end
            2'd1: begin
              if (e_nz) begin
                a_req <= 1'b1;
                a_we  <= 1'b1;
                a_wd  <= 8'h00;
                e_st  <= 2'd2;
              end else e_st <= 2'd3;
            end
            default: begin
              e_st <= 2'd0;
              if (&e_ptr) begin
                if (!e_ph) begin e_ph <= 1'b1; e_ptr <= '0; end
                else begin e_tmr <= 1'b1; tmr <= TW'(ERASE_CYC); end
              end else e_ptr <= e_ptr + 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/nor_cmd_engine_chk.sv
module nor_cmd_engine_chk #(
  parameter int ADDR_W = 21,
  parameter int SEC_W  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ry_by_n,
  input logic                  lv_det,
  input logic [(1<<SEC_W)-1:0] prot_mask,
  input logic                  arr_req,
  input logic                  arr_we,
  input logic [ADDR_W-1:0]     arr_addr,
  input logic [7:0]            arr_wdata,
  input logic                  arr_ack
);
  // R14
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && !arr_ack |=> arr_req && $stable(arr_addr) && $stable(arr_we) && $stable(arr_wdata));

  // R11
  prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req && arr_we |-> !prot_mask[arr_addr[ADDR_W-1 -: SEC_W]]);

  // R12
  lowv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lv_det && ry_by_n |=> ry_by_n);

  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ry_by_n) |-> !arr_req);
endmodule

bind nor_cmd_engine nor_cmd_engine_chk #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_chk (.*);

// File: tb/nor_cmd_engine_tb.sv
`timescale 1ns/100ps
module nor_cmd_engine_tb;
  localparam int AW = 12, SW = 5, PC = 40, EC = 16, WC = 20;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lv_det = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, arr_wdata, arr_rdata = '0;
  logic ry_by_n, arr_req, arr_we, arr_ack = 1'b0;
  logic [AW-1:0] arr_addr;
  logic [31:0] prot_mask = '0;

  always #2.5 clk = ~clk;

  nor_cmd_engine #(.ADDR_W(AW), .SEC_W(SW), .PROG_CYC(PC), .ERASE_CYC(EC), .WIN_CYC(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ry_by_n(ry_by_n), .lv_det(lv_det), .prot_mask(prot_mask), .arr_req(arr_req),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata), .arr_ack(arr_ack));

  int ncmp = 0, nfail = 0, ff_cnt = 0, bad_cnt = 0, drop_cnt = 0;
  logic [7:0] mem [DEPTH];
  logic [7:0] refm [DEPTH];
  logic mem_ok = 1'b0, req_q = 1'b0, ack_q = 1'b0;

  function automatic logic [7:0] iv(int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    if (!mem_ok) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= iv(i);
      mem_ok <= 1'b1;
    end else begin
      arr_ack <= 1'b0;
      if (arr_req && !arr_ack) begin
        arr_ack   <= 1'b1;
        arr_rdata <= mem[arr_addr];
        if (arr_we) begin
          mem[arr_addr] <= arr_wdata;
          if (arr_wdata == 8'hFF) begin
            ff_cnt <= ff_cnt + 1;
            if (mem[arr_addr] != 8'h00) bad_cnt <= bad_cnt + 1;
          end
        end
      end
    end
    req_q <= arr_req;
    ack_q <= arr_ack;
    if (rst_n && req_q && !ack_q && !arr_req) drop_cnt <= drop_cnt + 1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    ncmp++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs;
  event       got;

  initial forever begin
    @(got);
    if (exp_q.size() != 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(obs == e, t, obs, e);
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk);
    v = rdata; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd_exp(input logic [AW-1:0] a, input string tag);
    logic [7:0] v;
    exp_q.push_back(refm[a]);
    tag_q.push_back(tag);
    bus_rd(a, v);
    obs = v;
    -> got;
    #0.1;
  endtask

  task automatic unlock();
    bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); bus_wr(12'h555, 8'hA0); bus_wr(a, d);
  endtask

  task automatic sec_erase_cmd(input logic [AW-1:0] a);
    unlock(); bus_wr(12'h555, 8'h80); unlock(); bus_wr(a, 8'h30);
  endtask

  task automatic wait_ready(input int maxc, input string tag, output int cyc);
    cyc = 0;
    while (!ry_by_n && cyc < maxc) begin @(negedge clk); cyc++; end
    if (!ry_by_n) chk(1'b0, tag, cyc, maxc);
  endtask

  task automatic fill_sector(input int s, input logic [7:0] v);
    for (int i = 0; i < 128; i++) refm[s*128 + i] = v;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c, f0;
    logic [7:0] v1, v2;
    for (int i = 0; i < DEPTH; i++) refm[i] = iv(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ry_by_n == 1'b1, "R1 ready after reset", ry_by_n, 1);
    chk(arr_req == 1'b0, "R1 no request after reset", arr_req, 0);
    chk(rdata == 8'h00, "R1 rdata after reset", rdata, 0);
    rd_exp(12'h010, "R1 array read");

    // R2 / R3 / R4 program with status polling
    prog(12'h123, 8'h3C);
    chk(ry_by_n == 1'b0, "R3 busy after program", ry_by_n, 0);
    bus_rd(12'h123, v1);
    bus_rd(12'h123, v2);
    chk(v1[7] == 1'b1, "R4 polling bit", v1[7], 1);
    chk(v2[6] != v1[6], "R4 toggle bit", v2[6], ~v1[6]);
    wait_ready(200, "R3 program timeout", c);
    chk(c + 15 >= PC, "R3 busy length", c + 15, PC);
    refm[12'h123] = 8'h3C;
    rd_exp(12'h123, "R2 programmed byte");

    // R9 broken sequence
    unlock(); bus_wr(12'h555, 8'hAA); bus_wr(12'h555, 8'hA0); bus_wr(12'h200, 8'h77);
    chk(ry_by_n == 1'b1, "R9 no busy after broken sequence", ry_by_n, 1);
    rd_exp(12'h200, "R9 byte unchanged");

    // R8 bypass programming
    unlock(); bus_wr(12'h555, 8'h20);
    bus_wr(12'h000, 8'hA0); bus_wr(12'h300, 8'h81);
    wait_ready(200, "R8 bypass program timeout", c);
    bus_wr(12'h000, 8'hA0); bus_wr(12'h301, 8'h82);
    wait_ready(200, "R8 bypass program timeout", c);
    refm[12'h300] = 8'h81; refm[12'h301] = 8'h82;
    rd_exp(12'h300, "R8 bypass byte 0");
    rd_exp(12'h301, "R8 bypass byte 1");
    bus_wr(12'h000, 8'h90); bus_wr(12'h000, 8'h00);
    bus_wr(12'h000, 8'hA0); bus_wr(12'h302, 8'h99);
    chk(ry_by_n == 1'b1, "R8 short program ignored after exit", ry_by_n, 1);
    rd_exp(12'h302, "R8 byte unchanged after exit");

    // R11 protected program
    prot_mask = 32'h0000_0040;
    prog(12'h310, 8'h11);
    chk(ry_by_n == 1'b1, "R11 protected program not started", ry_by_n, 1);
    rd_exp(12'h310, "R11 protected byte unchanged");

    // R12 low supply
    lv_det = 1'b1;
    prog(12'h400, 8'h22);
    chk(ry_by_n == 1'b1, "R12 blocked under low supply", ry_by_n, 1);
    lv_det = 1'b0;
    rd_exp(12'h400, "R12 byte unchanged");

    // R5 / R7 sector erase with window
    f0 = ff_cnt;
    sec_erase_cmd(12'h180);
    bus_wr(12'h200, 8'h30);
    bus_wr(12'h300, 8'h30);
    chk(ry_by_n == 1'b0, "R3 busy during erase window", ry_by_n, 0);
    repeat (30) @(negedge clk);
    bus_rd(12'h000, v1);
    chk(v1[7] == 1'b0, "R4 polling bit during erase", v1[7], 0);
    wait_ready(20000, "R5 erase timeout", c);
    fill_sector(3, 8'hFF); fill_sector(4, 8'hFF);
    rd_exp(12'h190, "R5 sector 3 erased");
    rd_exp(12'h210, "R5 added sector 4 erased");
    rd_exp(12'h123, "R5 other sector kept");
    rd_exp(12'h310, "R11 protected sector kept by erase");
    chk(ff_cnt - f0 == 256, "R7 erase writes", ff_cnt - f0, 256);
    chk(bad_cnt == 0, "R7 pre-program before erase", bad_cnt, 0);

    // R10 suspend / resume
    sec_erase_cmd(12'h400);
    repeat (30) @(negedge clk);
    bus_wr(12'h000, 8'hB0);
    wait_ready(20, "R10 suspend latency", c);
    rd_exp(12'h500, "R10 read other sector while suspended");
    prog(12'h510, 8'h44);
    wait_ready(200, "R10 program in suspend timeout", c);
    refm[12'h510] = 8'h44;
    rd_exp(12'h510, "R10 program in suspend");
    prog(12'h420, 8'h12);
    chk(ry_by_n == 1'b1, "R10 program to erasing sector ignored", ry_by_n, 1);
    bus_wr(12'h000, 8'h30);
    chk(ry_by_n == 1'b0, "R10 busy after resume", ry_by_n, 0);
    wait_ready(20000, "R10 resumed erase timeout", c);
    fill_sector(8, 8'hFF);
    rd_exp(12'h420, "R10 erase completed");
    rd_exp(12'h510, "R10 suspended program kept");

    // R13 hardware reset aborts erase and partial sequence
    sec_erase_cmd(12'h600);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ry_by_n == 1'b1, "R13 ready after reset abort", ry_by_n, 1);
    rd_exp(12'h700, "R13 array read after abort");
    unlock();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_wr(12'h555, 8'hA0); bus_wr(12'h710, 8'h66);
    chk(ry_by_n == 1'b1, "R13 partial sequence cleared", ry_by_n, 1);
    rd_exp(12'h710, "R13 byte unchanged");

    // R6 chip erase
    f0 = ff_cnt;
    unlock(); bus_wr(12'h555, 8'h80); unlock(); bus_wr(12'h555, 8'h10);
    chk(ry_by_n == 1'b0, "R6 busy during chip erase", ry_by_n, 0);
    wait_ready(120000, "R6 chip erase timeout", c);
    for (int s = 0; s < 32; s++) if (s != 6) fill_sector(s, 8'hFF);
    rd_exp(12'h000, "R6 first byte erased");
    rd_exp(12'hFFF, "R6 last byte erased");
    rd_exp(12'h650, "R6 aborted sector erased");
    rd_exp(12'h301, "R6 protected sector kept");
    chk(ff_cnt - f0 == 31 * 128, "R7 chip erase writes", ff_cnt - f0, 31 * 128);
    chk(bad_cnt == 0, "R7 pre-program before chip erase", bad_cnt, 0);
    // R14 request never withdrawn before ack
    chk(drop_cnt == 0, "R14 request held until ack", drop_cnt, 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule